// File: doc/BRIEF.md
# Micro-Packet Transport Stream Reassembler

This block rebuilds 188-byte transport packets from a stream of 32-bit fragment words. Fragments from up to four tuner channels arrive interleaved. Each word names its channel, carries a 3-bit sequence count, a packet-start marker and an overflow indication from the capture device, and holds three payload bytes. For every channel the block keeps its own place within the packet. It serializes the bytes of each accepted fragment onto a byte output that is tagged with the channel number and marked at packet start and packet end.

A packet is made of 63 fragments. The first 62 give three bytes each and the last gives two, for 188 bytes in total. A fragment that arrives for a channel with no packet under way, and without the start marker, is thrown away. This lets the block find packet alignment again after loss. A jump in a channel's sequence count raises a one-cycle error pulse for that channel. The device overflow bit raises a separate one-cycle pulse.

Both sides use valid/ready handshakes. The input accepts one word, then holds off further words until that word's bytes have all left the output.

Top module: `mpr_ts_rebuild`

## Requirements
- R1: Bits 31:29 of a word carry a stream code. Codes 1, 2, 3 and 4 select channels 0, 1, 2 and 3, and out_chan carries that channel number. A word whose code is 0, 5, 6 or 7 is consumed and produces no output byte, no error pulse and no overflow pulse.
- R2: A kept fragment is emitted in byte order bits 23:16, then 15:8, then 7:0. When out_ready stays high, these bytes leave on consecutive cycles starting in the cycle after the word is accepted.
- R3: Bit 25 set marks the first fragment of a packet. It restarts that channel's packet even if a packet is already in progress, and out_sop is high on the first byte of that fragment only.
- R4: A fragment without bit 25, for a channel that has no packet in progress, is dropped. It produces no output, no pulses, and no change to that channel's sequence history.
- R5: The 63rd fragment of a packet gives only its bytes from bits 23:16 and 15:8. out_eop is high on the second of these, which is packet byte 188. After that the channel has no packet in progress.
- R6: Bits 28:26 hold a sequence count. If a kept fragment's count differs from that channel's previous kept count plus one (modulo 8), seq_err is high at that channel's bit for one cycle, in the cycle after acceptance. The first kept fragment of each channel after reset is not checked.
- R7: A kept fragment with bit 24 set drives ovf_pulse high for one cycle, in the cycle after acceptance.
- R8: in_ready is low from the cycle after a kept word is accepted until the cycle after its last byte is transferred. While out_valid is high and out_ready is low, the output byte, channel and markers hold steady.
- R9: Each channel keeps its packet position and sequence history independently, so interleaved fragments rebuild each channel's packets intact.
- R10: After reset, in_ready is 1, out_valid is 0, and seq_err and ovf_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Fragment word |
| in_valid | input | 1 | Fragment word present |
| in_ready | output | 1 | Block can take a word |
| out_data | output | 8 | Rebuilt packet byte |
| out_chan | output | 2 | Channel of the current byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Byte 188 of a packet |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| seq_err | output | 4 | One-cycle sequence-jump pulse, one bit per channel |
| ovf_pulse | output | 1 | One-cycle device overflow pulse |

## Verification
Two events can land in the same accepted word: the flag pulses (a sequence error or an overflow) and the start of byte output, which also carries a packet start or packet end. Words are built that carry a sequence jump and the overflow bit on a packet's first and last fragments. The bench checks the flag pulses in the cycle after acceptance, and the scoreboard checks the marked bytes as they come out. The same flags are also set on dropped and ignored-code words. For those words the pulses must stay low and no bytes may appear, which is judged both by the pulse check and by the scoreboard.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int WORD_W    = 32;
    localparam int PAY_BYTES = 3;
    localparam int SEQ_W     = 3;
    localparam int CODE_W    = 3;

    // Field layout of one fragment word, most significant first.
    typedef struct packed {
        logic [CODE_W-1:0]      code;
        logic [SEQ_W-1:0]       seq;
        logic                   first;
        logic                   ovf;
        logic [PAY_BYTES*8-1:0] pay;
    } frag_word_t;

endpackage

// File: rtl/mpr_word_decode.sv
module mpr_word_decode
    import mpr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [WORD_W-1:0]      word,
    output logic                   chan_hit,
    output logic [CH_W-1:0]        chan,
    output logic                   first,
    output logic                   ovf,
    output logic [SEQ_W-1:0]       seq,
    output logic [PAY_BYTES*8-1:0] pay
);

    frag_word_t        fw;
    logic [CODE_W-1:0] code_m1;

    always_comb begin
        fw       = frag_word_t'(word);
        code_m1  = fw.code - CODE_W'(1);
        chan_hit = (fw.code != '0) && (int'(fw.code) <= NUM_CH);
        chan     = code_m1[CH_W-1:0];
        first    = fw.first;
        ovf      = fw.ovf;
        seq      = fw.seq;
        pay      = fw.pay;
    end

endmodule

// File: rtl/mpr_chan_slot.sv
module mpr_chan_slot
    import mpr_pkg::*;
#(
    parameter int FRAGS = 63,
    parameter int FW    = $clog2(FRAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             first,
    input  logic [SEQ_W-1:0] seq,
    output logic             keep,
    output logic [FW-1:0]    frag_idx,
    output logic             seq_bad
);

    typedef struct packed {
        logic [FW-1:0]    frag;
        logic [SEQ_W-1:0] last_seq;
        logic             seen;
    } slot_t;

    slot_t            st_d, st_q;
    logic [SEQ_W-1:0] want_seq;

    always_comb begin
        want_seq = st_q.last_seq + SEQ_W'(1);
        frag_idx = first ? '0 : st_q.frag;
        keep     = first || (st_q.frag != '0);
        seq_bad  = st_q.seen && (seq != want_seq);

        st_d = st_q;
        if (sel && keep) begin
            st_d.frag     = (frag_idx == FW'(FRAGS - 1)) ? '0 : frag_idx + FW'(1);
            st_d.last_seq = seq;
            st_d.seen     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FRAG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.frag) < FRAGS);                                         // R5
    AST_DROP_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !keep) |=> $stable(st_q));                                // R4

endmodule

// File: rtl/mpr_byte_serial.sv
module mpr_byte_serial
    import mpr_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [PAY_BYTES*8-1:0] payload,
    input  logic                   two_only,
    input  logic [CH_W-1:0]        chan,
    input  logic                   sop_first,
    input  logic                   eop_last,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic [CH_W-1:0]        out_chan,
    output logic                   out_sop,
    output logic                   out_eop,
    output logic                   busy
);

    typedef struct packed {
        logic                   busy;
        logic [1:0]             idx;
        logic [1:0]             last;
        logic [PAY_BYTES*8-1:0] bytes;
        logic [CH_W-1:0]        chan;
        logic                   sopf;
        logic                   eopf;
    } ser_t;

    ser_t       st_d, st_q;
    logic [7:0] lane [PAY_BYTES];

    for (genvar g = 0; g < PAY_BYTES; g++) begin : g_lane
        assign lane[g] = st_q.bytes[(PAY_BYTES-1-g)*8 +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (st_q.busy && out_ready) begin
            if (st_q.idx == st_q.last) st_d.busy = 1'b0;
            else                       st_d.idx  = st_q.idx + 2'd1;
        end
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.idx   = 2'd0;
            st_d.last  = two_only ? 2'd1 : 2'(PAY_BYTES - 1);
            st_d.bytes = payload;
            st_d.chan  = chan;
            st_d.sopf  = sop_first;
            st_d.eopf  = eop_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        busy      = st_q.busy;
        out_valid = st_q.busy;
        out_data  = lane[st_q.idx];
        out_chan  = st_q.chan;
        out_sop   = st_q.sopf && (st_q.idx == 2'd0);
        out_eop   = st_q.eopf && (st_q.idx == st_q.last);
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan))); // R8
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);                                                   // R8

endmodule

// File: rtl/mpr_ts_rebuild.sv
module mpr_ts_rebuild
    import mpr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int FRAGS  = 63,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int FW     = $clog2(FRAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NUM_CH-1:0] seq_err,
    output logic              ovf_pulse
);

    typedef struct packed {
        logic [NUM_CH-1:0] seq_err;
        logic              ovf;
    } stat_t;

    logic                   dec_hit, dec_first, dec_ovf;
    logic [CH_W-1:0]        dec_chan;
    logic [SEQ_W-1:0]       dec_seq;
    logic [PAY_BYTES*8-1:0] dec_pay;

    logic [NUM_CH-1:0] slot_sel, slot_keep, slot_bad;
    logic [FW-1:0]     slot_frag [NUM_CH];

    logic          accept, load, ser_busy;
    logic          keep_sel, bad_sel;
    logic [FW-1:0] frag_sel;
    stat_t         stat_d, stat_q;

    mpr_word_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
        .word     (in_data),
        .chan_hit (dec_hit),
        .chan     (dec_chan),
        .first    (dec_first),
        .ovf      (dec_ovf),
        .seq      (dec_seq),
        .pay      (dec_pay)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        assign slot_sel[c] = accept && dec_hit && (dec_chan == CH_W'(c));
        mpr_chan_slot #(.FRAGS(FRAGS), .FW(FW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (slot_sel[c]),
            .first    (dec_first),
            .seq      (dec_seq),
            .keep     (slot_keep[c]),
            .frag_idx (slot_frag[c]),
            .seq_bad  (slot_bad[c])
        );
    end

    always_comb begin
        in_ready = !ser_busy;
        accept   = in_valid && in_ready;
        keep_sel = dec_hit && slot_keep[dec_chan];
        bad_sel  = slot_bad[dec_chan];
        frag_sel = slot_frag[dec_chan];
        load     = accept && keep_sel;

        stat_d = '0;
        if (load) begin
            stat_d.ovf = dec_ovf;
            if (bad_sel) stat_d.seq_err[dec_chan] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign seq_err   = stat_q.seq_err;
    assign ovf_pulse = stat_q.ovf;

    mpr_byte_serial #(.CH_W(CH_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .payload   (dec_pay),
        .two_only  (frag_sel == FW'(FRAGS - 1)),
        .chan      (dec_chan),
        .sop_first (frag_sel == '0),
        .eop_last  (frag_sel == FW'(FRAGS - 1)),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_chan  (out_chan),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .busy      (ser_busy)
    );

    AST_SEQ_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_err));                                               // R6
    AST_IGNORED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_hit) |=> (!out_valid && !ovf_pulse && seq_err == '0)); // R1
    AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);                                         // R8
    AST_SOP_EOP_APART: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));                             // R5

endmodule

// File: tb/mpr_ts_rebuild_test.sv
`timescale 1ns/1ps
module mpr_ts_rebuild_test;

    localparam real HALF = 10.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic [1:0]  out_chan;
    logic        out_sop, out_eop, out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  seq_err;
    logic        ovf_pulse;

    mpr_ts_rebuild uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_chan(out_chan),
        .out_sop(out_sop), .out_eop(out_eop), .out_valid(out_valid),
        .out_ready(out_ready), .seq_err(seq_err), .ovf_pulse(ovf_pulse)
    );

    always #(HALF) clk = ~clk;

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] d;
        logic       sop;
        logic       eop;
    } beat_t;

    beat_t expq[$];
    int    n_chk = 0;
    int    n_fail = 0;

    int         mf [4];
    bit         mseen [4];
    logic [2:0] mseq [4];
    logic [2:0] gseq [4];

    bit          bp = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit          held_v = 1'b0;
    beat_t       held;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= bp ? lfsr[0] : 1'b1;
    end

    // Monitor: compares each transferred byte with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v)
                chk(out_valid && {out_chan, out_data, out_sop, out_eop} == held,
                    "R8", "stalled byte changed", int'(out_data), int'(held.d));
            held_v = 1'b0;
            if (out_valid) begin
                chk(!in_ready, "R8", "in_ready while emitting", int'(in_ready), 0);
                if (out_ready) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R1", "unexpected byte", int'(out_data), -1);
                    end else begin
                        beat_t e;
                        e = expq.pop_front();
                        chk(out_chan == e.ch, "R9", "channel", int'(out_chan), int'(e.ch));
                        chk(out_data == e.d, "R2", "data", int'(out_data), int'(e.d));
                        chk(out_sop == e.sop, "R3", "sop", int'(out_sop), int'(e.sop));
                        chk(out_eop == e.eop, "R5", "eop", int'(out_eop), int'(e.eop));
                    end
                end else begin
                    held_v = 1'b1;
                    held = {out_chan, out_data, out_sop, out_eop};
                end
            end
        end
    end

    function automatic logic [31:0] mk(input logic [2:0] code, input bit st,
                                       input bit ov, input logic [2:0] sq,
                                       input logic [23:0] pl);
        return {code, sq, st, ov, pl};
    endfunction

    // Driver: model the word, queue expected bytes, hand it over, check pulses
    task automatic send(input logic [31:0] w);
        logic [2:0] code;
        bit         exp_ovf;
        logic [3:0] exp_err;
        code = w[31:29];
        exp_ovf = 1'b0;
        exp_err = '0;
        if (code >= 3'd1 && code <= 3'd4) begin
            int ch;
            ch = int'(code) - 1;
            if (w[25]) mf[ch] = 0;
            if (w[25] || mf[ch] != 0) begin
                int nb;
                if (mseen[ch] && w[28:26] != 3'(mseq[ch] + 3'd1)) exp_err[ch] = 1'b1;
                mseen[ch] = 1'b1;
                mseq[ch] = w[28:26];
                exp_ovf = w[24];
                nb = (mf[ch] == 62) ? 2 : 3;
                for (int i = 0; i < nb; i++) begin
                    beat_t b;
                    b.ch  = 2'(ch);
                    b.d   = w[23 - 8*i -: 8];
                    b.sop = (mf[ch] == 0) && (i == 0);
                    b.eop = (mf[ch] == 62) && (i == 1);
                    expq.push_back(b);
                end
                mf[ch] = (mf[ch] == 62) ? 0 : mf[ch] + 1;
            end
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(seq_err == exp_err, "R6", "seq_err pulse", int'(seq_err), int'(exp_err));
        chk(ovf_pulse == exp_ovf, "R7", "ovf pulse", int'(ovf_pulse), int'(exp_ovf));
    endtask

    task automatic frag(input int ch, input bit st, input bit ov);
        send(mk(3'(ch + 1), st, ov, gseq[ch], 24'($urandom)));
        gseq[ch] = gseq[ch] + 3'd1;
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((expq.size() != 0 || out_valid) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(expq.size() == 0, tag, "bytes left after drain", expq.size(), 0);
    endtask

    task automatic quiet(input string tag);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_valid) chk(1'b0, tag, "output after dropped word", 1, 0);
        end
        chk(!out_valid, tag, "output idle", int'(out_valid), 0);
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            mf[c] = 0; mseen[c] = 1'b0; mseq[c] = '0; gseq[c] = 3'(c + 5);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(in_ready == 1'b1, "R10", "in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
        chk(seq_err == 4'b0, "R10", "seq_err", int'(seq_err), 0);
        chk(ovf_pulse == 1'b0, "R10", "ovf_pulse", int'(ovf_pulse), 0);

        // R2 R5: one full packet on channel 0, overflow on first and last fragment
        for (int f = 0; f < 63; f++) frag(0, f == 0, f == 0 || f == 62);
        drain("R5");

        // R4: non-start fragment with no packet in progress, bad sequence, overflow set
        send(mk(3'd1, 1'b0, 1'b1, 3'(gseq[0] + 3'd3), 24'h123456));
        quiet("R4");
        send(mk(3'd2, 1'b0, 1'b1, 3'd0, 24'h654321));
        quiet("R4");

        // R1: ignored stream codes with start and overflow set
        send(mk(3'd0, 1'b1, 1'b1, 3'd0, 24'hAAAAAA));
        send(mk(3'd5, 1'b1, 1'b1, 3'd1, 24'hBBBBBB));
        send(mk(3'd6, 1'b1, 1'b1, 3'd2, 24'hCCCCCC));
        send(mk(3'd7, 1'b1, 1'b1, 3'd3, 24'hDDDDDD));
        quiet("R1");

        // R9 R8: three channels interleaved under random backpressure, ignored codes mixed in
        bp = 1'b1;
        for (int f = 0; f < 63; f++) begin
            for (int c = 1; c < 4; c++) frag(c, f == 0, 1'b0);
            if (f % 9 == 4) send(mk(3'd6, 1'b0, 1'b1, 3'd0, 24'(f)));
        end
        drain("R9");

        // R6: sequence jump on a packet start, and a jump mid-packet on channel 2
        gseq[2] = gseq[2] + 3'd2;
        frag(2, 1'b1, 1'b1);
        frag(2, 1'b0, 1'b0);
        gseq[2] = gseq[2] + 3'd4;
        frag(2, 1'b0, 1'b0);
        drain("R6");

        // R3: restart mid-packet on channel 3, then complete the new packet
        for (int f = 0; f < 5; f++) frag(3, f == 0, 1'b0);
        for (int f = 0; f < 63; f++) frag(3, f == 0, f == 30);
        drain("R3");

        // R7: overflow on kept word while channel 2 packet is still running
        frag(2, 1'b0, 1'b1);
        bp = 1'b0;
        drain("R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule